// File: doc/BRIEF.md
# Secure Branch-and-Exchange Control

This block sits in the execute stage of a core that has a security extension. It decodes the 16-bit register branch-and-exchange group and runs the branch form that crosses into another security state. The core gives it the instruction word, the target register value, the current security state, whether the extension is present, and whether the core runs in a user-only setting. One cycle later it reports the result as single-cycle strobes. The possible results are a program counter load, an undefined-instruction trap, an exception-return request, or a request to the banked stack-pointer unit to switch security state.

For the security-crossing form, bit 0 of the target picks the destination security state. Bit 0 does not pick the instruction set for this form: the instruction-set bit is forced to 1. Targets in the top address window are magic values. These are not jumps: they are passed on as an exception return. The ordinary branch-and-exchange forms of the group are not executed here. They are only forwarded, together with the index of their source register, to the ordinary branch path.

Top module: `sbx_ctrl`

## Requirements
- R1: Every output is registered. A strobe (`undef`, `pc_load`, `exc_return`, `sw_req`, `it_clear`, `fwd_plain`) is high for exactly the one cycle after a cycle with `insn_valid` high. An instruction whose bits 15:8 are not 0x47, or a cycle without `insn_valid`, raises no strobe.
- R2: In the group (bits 15:8 = 0x47), nonzero bits 1:0 raise `undef`.
- R3: The security-crossing form (bit 2 set, bits 1:0 zero) raises `undef` unless `cur_secure`=1, `sec_ext`=1 and `user_only`=0.
- R4: The linking security-crossing form (bits 7 and 2 set) raises `undef` even when it is otherwise allowed.
- R5: An allowed crossing branch whose target is at or above 0xFF000000 raises `exc_return` and `pc_load`, with `pc_value` = target with bit 0 cleared and `isa_bit` = target bit 0. It raises no `sw_req`.
- R6: Any other allowed crossing branch raises `pc_load` with `pc_value` = target with bit 0 cleared and `isa_bit` = 1.
- R7: Such a branch also raises `sw_req`, with `sw_secure` = target bit 0 (1 Secure, 0 Non-secure).
- R8: Each executed crossing branch (R5 or R6) raises `it_clear` to cancel pending conditional-block state.
- R9: When `undef` is high, `pc_load`, `exc_return`, `sw_req` and `it_clear` are low.
- R10: The plain forms (bit 2 clear, bits 1:0 zero, bit 7 either value) raise only `fwd_plain`, with `fwd_reg` = bits 6:3.
- R11: While `rst_n` is low all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction present this cycle |
| insn | input | 16 | Instruction word |
| target | input | 32 | Value read from the branch register |
| cur_secure | input | 1 | Core is in Secure state |
| sec_ext | input | 1 | Security extension present |
| user_only | input | 1 | User-only execution setting |
| pc_load | output | 1 | Load `pc_value` into the program counter |
| pc_value | output | 32 | New program counter |
| isa_bit | output | 1 | New instruction-set state bit |
| undef | output | 1 | Undefined-instruction trap |
| exc_return | output | 1 | Exception-return request |
| sw_req | output | 1 | Security-switch request to the stack-pointer unit |
| sw_secure | output | 1 | Requested security state |
| it_clear | output | 1 | Clear conditional-block state |
| fwd_plain | output | 1 | Plain branch forwarded to the ordinary path |
| fwd_reg | output | 4 | Source register index of the forwarded branch |

## Verification
The bench targets these corner cases:
- A target of exactly 0xFF000000 and a target of 0xFEFFFFFF, on either side of the magic window. An off-by-one compare would turn a real jump into an exception return, or the reverse.
- Odd targets on both paths. A design that kept bit 0 in the program counter, or that used bit 0 as the instruction-set bit on a normal crossing, shows up here.
- Each gating input dropped on its own, and the linking form. A design that leaked a stack-pointer switch or a program counter load alongside the trap would corrupt banked state.
- Back-to-back valid instructions and idle gaps between them, which expose strobes that stretch past one cycle.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_PLAIN = 3'd1,
    K_UNDEF = 3'd2,
    K_XRET  = 3'd3,
    K_NSBR  = 3'd4
  } sbx_kind_e;

  // Target falls into the exception-return window
  function automatic logic in_magic(input logic [31:0] t, input logic [31:0] base);
    return t >= base;
  endfunction

  // Branch address with the selector bit stripped
  function automatic logic [31:0] strip_lsb(input logic [31:0] t);
    return {t[31:1], 1'b0};
  endfunction

  // Crossing form permitted in current context
  function automatic logic cross_allowed(input logic sec, input logic ext, input logic uo);
    return sec & ext & ~uo;
  endfunction

endpackage

// File: rtl/sbx_decode.sv
module sbx_decode
  import sbx_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [7:0] GRP_OPC = 8'h47,
  parameter logic [AW-1:0] MAGIC_BASE = 32'hFF00_0000
) (
  input  logic          valid,
  input  logic [15:0]   insn,
  input  logic [AW-1:0] target,
  input  logic          cur_secure,
  input  logic          sec_ext,
  input  logic          user_only,
  output sbx_kind_e     kind
);
  logic grp_hit, low_bad, ns_form, link_bit, allowed, magic;

  assign grp_hit  = valid && (insn[15:8] == GRP_OPC);
  assign low_bad  = insn[1:0] != 2'b00;
  assign ns_form  = insn[2];
  assign link_bit = insn[7];
  assign allowed  = cross_allowed(cur_secure, sec_ext, user_only);
  assign magic    = in_magic(target, MAGIC_BASE);

  always_comb begin
    kind = K_NONE;
    if (grp_hit) begin
      if (low_bad)                 kind = K_UNDEF;
      else if (!ns_form)           kind = K_PLAIN;
      else if (!allowed)           kind = K_UNDEF;
      else if (link_bit)           kind = K_UNDEF;
      else if (magic)              kind = K_XRET;
      else                         kind = K_NSBR;
    end
  end
endmodule

// File: rtl/sbx_exec.sv
module sbx_exec
  import sbx_pkg::*;
#(
  parameter int AW = 32
) (
  input  sbx_kind_e     kind,
  input  logic [AW-1:0] target,
  input  logic [3:0]    rm,
  output logic          n_pc_load,
  output logic [AW-1:0] n_pc,
  output logic          n_isa,
  output logic          n_undef,
  output logic          n_xret,
  output logic          n_sw,
  output logic          n_sw_sec,
  output logic          n_it_clr,
  output logic          n_plain,
  output logic [3:0]    n_rm
);
  always_comb begin
    n_pc_load = 1'b0;
    n_pc      = '0;
    n_isa     = 1'b0;
    n_undef   = 1'b0;
    n_xret    = 1'b0;
    n_sw      = 1'b0;
    n_sw_sec  = 1'b0;
    n_it_clr  = 1'b0;
    n_plain   = 1'b0;
    n_rm      = '0;
    unique case (kind)
      K_UNDEF: n_undef = 1'b1;
      K_PLAIN: begin
        n_plain = 1'b1;
        n_rm    = rm;
      end
      K_XRET: begin
        n_pc_load = 1'b1;
        n_pc      = strip_lsb(target);
        n_isa     = target[0];
        n_xret    = 1'b1;
        n_it_clr  = 1'b1;
      end
      K_NSBR: begin
        n_pc_load = 1'b1;
        n_pc      = strip_lsb(target);
        n_isa     = 1'b1;
        n_sw      = 1'b1;
        n_sw_sec  = target[0];
        n_it_clr  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbx_ctrl.sv
module sbx_ctrl
  import sbx_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [7:0] GRP_OPC = 8'h47,
  parameter logic [AW-1:0] MAGIC_BASE = 32'hFF00_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_valid,
  input  logic [15:0]   insn,
  input  logic [AW-1:0] target,
  input  logic          cur_secure,
  input  logic          sec_ext,
  input  logic          user_only,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          isa_bit,
  output logic          undef,
  output logic          exc_return,
  output logic          sw_req,
  output logic          sw_secure,
  output logic          it_clear,
  output logic          fwd_plain,
  output logic [3:0]    fwd_reg
);
  sbx_kind_e     kind;
  logic          n_pc_load, n_isa, n_undef, n_xret, n_sw, n_sw_sec, n_it_clr, n_plain;
  logic [AW-1:0] n_pc;
  logic [3:0]    n_rm;

  sbx_decode #(.AW(AW), .GRP_OPC(GRP_OPC), .MAGIC_BASE(MAGIC_BASE)) u_dec (
    .valid(insn_valid), .insn(insn), .target(target),
    .cur_secure(cur_secure), .sec_ext(sec_ext), .user_only(user_only),
    .kind(kind)
  );

  sbx_exec #(.AW(AW)) u_exe (
    .kind(kind), .target(target), .rm(insn[6:3]),
    .n_pc_load(n_pc_load), .n_pc(n_pc), .n_isa(n_isa), .n_undef(n_undef),
    .n_xret(n_xret), .n_sw(n_sw), .n_sw_sec(n_sw_sec), .n_it_clr(n_it_clr),
    .n_plain(n_plain), .n_rm(n_rm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load    <= 1'b0;
      pc_value   <= '0;
      isa_bit    <= 1'b0;
      undef      <= 1'b0;
      exc_return <= 1'b0;
      sw_req     <= 1'b0;
      sw_secure  <= 1'b0;
      it_clear   <= 1'b0;
      fwd_plain  <= 1'b0;
      fwd_reg    <= '0;
    end else begin
      pc_load    <= n_pc_load;
      pc_value   <= n_pc;
      isa_bit    <= n_isa;
      undef      <= n_undef;
      exc_return <= n_xret;
      sw_req     <= n_sw;
      sw_secure  <= n_sw_sec;
      it_clear   <= n_it_clr;
      fwd_plain  <= n_plain;
      fwd_reg    <= n_rm;
    end
  end

  // R9: a trap never carries side effects
  p_undef_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !pc_load && !exc_return && !sw_req && !it_clear);

  // R1: strobes only follow an accepted instruction
  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (undef || pc_load || fwd_plain) |-> $past(insn_valid));

  // R1: at most one kind of result per cycle
  p_one_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef, fwd_plain, sw_req, exc_return}));

  // R5: exception return only from the magic window
  p_xret_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return |-> pc_load && (pc_value >= MAGIC_BASE));

  // R6: a stack switch always comes with the instruction-set bit set
  p_switch_isa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> pc_load && isa_bit);

  // R6: loaded program counter is halfword aligned
  p_pc_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> !pc_value[0]);

  // R8: conditional state cleared exactly with executed crossing branches
  p_itclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    it_clear == (sw_req || exc_return));
endmodule

// File: tb/test_sbx_ctrl.sv
module test_sbx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [15:0] insn = '0;
  logic [31:0] target = '0;
  logic        cur_secure = 1'b0, sec_ext = 1'b0, user_only = 1'b0;
  logic        pc_load, isa_bit, undef, exc_return, sw_req, sw_secure, it_clear, fwd_plain;
  logic [31:0] pc_value;
  logic [3:0]  fwd_reg;

  always #2 clk = ~clk;

  sbx_ctrl i_sbx_ctrl (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .target(target),
    .cur_secure(cur_secure), .sec_ext(sec_ext), .user_only(user_only),
    .pc_load(pc_load), .pc_value(pc_value), .isa_bit(isa_bit), .undef(undef),
    .exc_return(exc_return), .sw_req(sw_req), .sw_secure(sw_secure),
    .it_clear(it_clear), .fwd_plain(fwd_plain), .fwd_reg(fwd_reg)
  );

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  // expected values for the next compare
  bit e_pc, e_isa, e_und, e_xr, e_sw, e_sws, e_it, e_pl;
  logic [31:0] e_pcv;
  logic [3:0]  e_rm;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R9/R2/R3/R4", "undef", {31'd0, undef}, {31'd0, e_und});
    chk("R6", "pc_load", {31'd0, pc_load}, {31'd0, e_pc});
    chk("R5", "exc_return", {31'd0, exc_return}, {31'd0, e_xr});
    chk("R7", "sw_req", {31'd0, sw_req}, {31'd0, e_sw});
    chk("R8", "it_clear", {31'd0, it_clear}, {31'd0, e_it});
    chk("R10", "fwd_plain", {31'd0, fwd_plain}, {31'd0, e_pl});
    if (e_pc) begin
      chk("R6", "pc_value", pc_value, e_pcv);
      chk("R5", "isa_bit", {31'd0, isa_bit}, {31'd0, e_isa});
    end
    if (e_sw) chk("R7", "sw_secure", {31'd0, sw_secure}, {31'd0, e_sws});
    if (e_pl) chk("R10", "fwd_reg", {28'd0, fwd_reg}, {28'd0, e_rm});
  endtask

  // behavioural reference model
  task automatic model(input bit v, input logic [15:0] w, input logic [31:0] t,
                       input bit s, input bit x, input bit u);
    e_pc = 0; e_isa = 0; e_und = 0; e_xr = 0; e_sw = 0; e_sws = 0; e_it = 0; e_pl = 0;
    e_pcv = 0; e_rm = 0;
    if (!v || w[15:8] != 8'h47) return;
    if (w[1:0] != 0) begin e_und = 1; return; end          // R2
    if (!w[2]) begin e_pl = 1; e_rm = w[6:3]; return; end   // R10
    if (!(s && x && !u) || w[7]) begin e_und = 1; return; end // R3 R4
    e_pc = 1; e_it = 1; e_pcv = t & 32'hFFFF_FFFE;
    if (t[31:24] == 8'hFF) begin e_xr = 1; e_isa = t[0]; end // R5
    else begin e_isa = 1; e_sw = 1; e_sws = t[0]; end        // R6 R7
  endtask

  task automatic apply(input bit v, input logic [15:0] w, input logic [31:0] t,
                       input bit s, input bit x, input bit u);
    @(negedge clk);
    compare();
    insn_valid = v; insn = w; target = t; cur_secure = s; sec_ext = x; user_only = u;
    model(v, w, t, s, x, u);
  endtask

  initial begin
    #400000;
    if (!done) begin
      misses++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    model(0, 0, 0, 0, 0, 0);
    // R11: reset state
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    apply(0, 16'h4704, 32'h1000, 1, 1, 0);        // R1 no valid
    apply(1, 16'h4604, 32'h1000, 1, 1, 0);        // R1 other group
    apply(1, 16'h4750, 32'h2001, 1, 1, 0);        // R10 plain BX r10
    apply(1, 16'h47C8, 32'h2001, 0, 0, 1);        // R10 plain linked r9
    apply(1, 16'h4705, 32'h3000, 1, 1, 0);        // R2
    apply(1, 16'h4702, 32'h3000, 1, 1, 0);        // R2
    apply(1, 16'h4724, 32'h0000_4000, 1, 1, 0);   // R6 R7 to NS
    apply(1, 16'h4724, 32'h0000_4001, 1, 1, 0);   // R7 stays S, isa forced
    apply(1, 16'h4724, 32'hFF00_0000, 1, 1, 0);   // R5 boundary
    apply(1, 16'h4724, 32'hFEFF_FFFF, 1, 1, 0);   // R6 just below
    apply(1, 16'h4724, 32'hFFFF_FFFD, 1, 1, 0);   // R5 odd magic
    apply(1, 16'h4724, 32'h5000, 0, 1, 0);        // R3 non-secure
    apply(1, 16'h4724, 32'h5000, 1, 0, 0);        // R3 no extension
    apply(1, 16'h4724, 32'h5000, 1, 1, 1);        // R3 user-only
    apply(1, 16'h47A4, 32'h5000, 1, 1, 0);        // R4 linked crossing
    apply(0, 16'h4724, 32'h5000, 1, 1, 0);        // R1 pulse ends
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      logic [31:0] t;
      w = {((i % 5) == 0) ? 8'h46 : 8'h47, 8'($urandom)};
      t = ($urandom % 3 == 0) ? {8'hFF, 24'($urandom)} : $urandom;
      apply(1'($urandom % 8 != 0), w, t, 1'($urandom % 4 != 0), 1'($urandom % 6 != 0), 1'($urandom % 6 == 0));
    end
    apply(0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule